// File: doc/BRIEF.md
# Multi-channel interrupt status aggregator

This block holds the event status of a group of serial bus channels and folds it into one controller-level summary. Each channel engine reports events as single-cycle pulses on a 15-bit lane. The block keeps a 15-bit enable mask and a 15-bit status word for each channel. When events arrive on a lane, the channel status becomes the old status ORed with the new events, then ANDed with the enable mask. Events that are not enabled are therefore dropped and never latched.

A host register port reads and writes the per-channel enable and status registers and reads a summary word. Status is cleared by writing ones. The summary holds one bit per channel. A bit is set when a posting leaves the channel status nonzero. It is cleared only when a status clear write leaves that channel empty. The interrupt outputs follow the summary. A parameter selects one line per channel or a single shared line that is the OR of all summary bits.

Top module: `irq_agg`

## Requirements
- R1: After reset, every channel's status and enable read as zero, the summary reads zero, and every interrupt line is low.
- R2: An enable write stores bits 14:0 of the write data. Bits 31:15 of an enable read are always zero.
- R3: In a cycle where a channel's event lane is nonzero, its next status is (status | events) & enable, using the enable value held before that cycle. Event bits that are not enabled are lost.
- R4: When a posting leaves a channel status nonzero, summary bit c (c being the channel index) is set on the next cycle, and so is that channel's interrupt.
- R5: A write to a channel's status register clears each status bit whose write-data bit is 1 (bits 14:0 only). Bits written 0, and write bits 31:15, have no effect.
- R6: A summary bit, and the interrupt it drives, drops only after a status clear write that leaves that channel's status zero. A posting whose masked result is zero leaves the summary bit as it was.
- R7: If one cycle carries both a clear write and an enabled event for the same status bit, the bit ends up set.
- R8: The summary register is read-only. A write to it changes no state.
- R9: With SHARED_IRQ=0 there is one interrupt line per channel, equal to that channel's summary bit. With SHARED_IRQ=1 there is one line, equal to the OR of all summary bits.
- R10: Address bits [1:0] select the register: 0 enable, 1 status, 2 summary, 3 reserved (reads zero). The upper address bits give the channel index. Reads are combinational from the current address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_pulse | input | N_CH*EVT_W | Event pulses; lane c occupies bits c*EVT_W +: EVT_W (bit 0 ack, 1 nak, 2 receive done, 3 arbitration lost, 4 clean stop, 5 bad stop, 6 clock timeout) |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | CH_W+2 | Host address: channel index above a 2-bit register select |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Host read data for host_addr |
| sum_vec | output | N_CH | Per-channel summary bits |
| irq | output | SHARED_IRQ ? 1 : N_CH | Interrupt line(s) |

## Verification
The block is driven with these patterns:
- An event word that mixes enabled and disabled bits, which shows whether masking happens when an event is posted or only when it is read.
- Partial and full clear writes, some with upper data bits set, which check that the summary bit is held until the channel is empty and that bits above 14 have no effect.
- A clear and an event on the same bit in one cycle, and a posting whose masked result is zero; these two corners distinguish the set-wins rule and the sticky summary from simpler readings of the requirements.
- A long stretch of random writes and sparse events on two instances, one per interrupt mode, compared every cycle against a behavioural model.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

   // register select carried in host address bits [1:0]
   typedef enum logic [1:0] {
      REG_ENABLE  = 2'd0,
      REG_STATUS  = 2'd1,
      REG_SUMMARY = 2'd2,
      REG_RSVD    = 2'd3
   } reg_sel_e;

   // event lane bit positions driven by the channel engines
   localparam int EV_ACK       = 0;
   localparam int EV_NAK       = 1;
   localparam int EV_RX_DONE   = 2;
   localparam int EV_ARB_LOST  = 3;
   localparam int EV_STOP_OK   = 4;
   localparam int EV_STOP_BAD  = 5;
   localparam int EV_CLK_TMO   = 6;

endpackage

// File: rtl/irq_agg_chan.sv
module irq_agg_chan #(
   parameter int EVT_W = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [EVT_W-1:0] evt_in,
   input  logic             en_wr,
   input  logic             st_wr,
   input  logic [EVT_W-1:0] wbits,
   output logic [EVT_W-1:0] en_q,
   output logic [EVT_W-1:0] st_q,
   output logic             sum_q
);

   logic             posting;
   logic [EVT_W-1:0] kept;
   logic [EVT_W-1:0] st_nx;
   logic             sum_nx;

   always_comb begin
      posting = |evt_in;
      // clear first, then OR events so a same-cycle set wins (R7)
      kept    = st_wr ? (st_q & ~wbits) : st_q;
      st_nx   = posting ? ((kept | evt_in) & en_q) : kept;
      sum_nx  = sum_q;
      if (posting && (st_nx != '0))
         sum_nx = 1'b1;
      else if (st_wr && (st_nx == '0))
         sum_nx = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q  <= '0;
         st_q  <= '0;
         sum_q <= 1'b0;
      end else begin
         st_q  <= st_nx;
         sum_q <= sum_nx;
         if (en_wr)
            en_q <= wbits;
      end
   end

endmodule

// File: rtl/irq_agg_host.sv
module irq_agg_host
   import irq_agg_pkg::*;
#(
   parameter int N_CH   = 4,
   parameter int EVT_W  = 15,
   parameter int DATA_W = 32,
   parameter int CH_W   = 2,
   parameter int ADDR_W = 4
) (
   input  logic                    host_wr,
   input  logic [ADDR_W-1:0]       host_addr,
   input  logic [N_CH*EVT_W-1:0]   en_flat,
   input  logic [N_CH*EVT_W-1:0]   st_flat,
   input  logic [N_CH-1:0]         sum_vec,
   output logic [N_CH-1:0]         en_wr,
   output logic [N_CH-1:0]         st_wr,
   output logic [DATA_W-1:0]       rdata
);

   reg_sel_e        sel;
   logic [CH_W-1:0] ch;

   assign sel = reg_sel_e'(host_addr[1:0]);
   assign ch  = host_addr[ADDR_W-1:2];

   // write strobes per channel; summary and reserved selects take no write
   for (genvar c = 0; c < N_CH; c++) begin : g_dec
      assign en_wr[c] = host_wr && (sel == REG_ENABLE) && (ch == CH_W'(c));
      assign st_wr[c] = host_wr && (sel == REG_STATUS) && (ch == CH_W'(c));
   end

   always_comb begin
      rdata = '0;
      case (sel)
         REG_ENABLE: begin
            for (int c = 0; c < N_CH; c++)
               if (ch == CH_W'(c))
                  rdata[EVT_W-1:0] = en_flat[c*EVT_W +: EVT_W];
         end
         REG_STATUS: begin
            for (int c = 0; c < N_CH; c++)
               if (ch == CH_W'(c))
                  rdata[EVT_W-1:0] = st_flat[c*EVT_W +: EVT_W];
         end
         REG_SUMMARY: rdata[N_CH-1:0] = sum_vec;
         default:     rdata = '0;
      endcase
   end

endmodule

// File: rtl/irq_agg_irqmap.sv
module irq_agg_irqmap #(
   parameter int N_CH       = 4,
   parameter bit SHARED_IRQ = 1'b0,
   parameter int IRQ_W      = SHARED_IRQ ? 1 : N_CH
) (
   input  logic [N_CH-1:0]  sum_vec,
   output logic [IRQ_W-1:0] irq
);

   if (SHARED_IRQ) begin : g_shared
      assign irq = IRQ_W'(|sum_vec);
   end else begin : g_per_chan
      assign irq = sum_vec;
   end

endmodule

// File: rtl/irq_agg.sv
module irq_agg
   import irq_agg_pkg::*;
#(
   parameter int N_CH       = 4,
   parameter int EVT_W      = 15,
   parameter int DATA_W     = 32,
   parameter bit SHARED_IRQ = 1'b0,
   parameter int CH_W       = (N_CH > 1) ? $clog2(N_CH) : 1,
   parameter int ADDR_W     = CH_W + 2
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [N_CH*EVT_W-1:0]             evt_pulse,
   input  logic                              host_wr,
   input  logic [ADDR_W-1:0]                 host_addr,
   input  logic [DATA_W-1:0]                 host_wdata,
   output logic [DATA_W-1:0]                 host_rdata,
   output logic [N_CH-1:0]                   sum_vec,
   output logic [(SHARED_IRQ ? 1 : N_CH)-1:0] irq
);

   localparam int IRQ_W = SHARED_IRQ ? 1 : N_CH;

   if (N_CH < 1 || N_CH > DATA_W) begin : g_bad_nch
      $error("irq_agg: N_CH must lie in 1..DATA_W");
   end
   if (EVT_W < 1 || EVT_W >= DATA_W) begin : g_bad_evtw
      $error("irq_agg: EVT_W must lie in 1..DATA_W-1");
   end

   logic [N_CH*EVT_W-1:0] en_flat;
   logic [N_CH*EVT_W-1:0] st_flat;
   logic [N_CH-1:0]       en_wr;
   logic [N_CH-1:0]       st_wr;

   irq_agg_host #(
      .N_CH(N_CH), .EVT_W(EVT_W), .DATA_W(DATA_W), .CH_W(CH_W), .ADDR_W(ADDR_W)
   ) u_host (
      .host_wr   (host_wr),
      .host_addr (host_addr),
      .en_flat   (en_flat),
      .st_flat   (st_flat),
      .sum_vec   (sum_vec),
      .en_wr     (en_wr),
      .st_wr     (st_wr),
      .rdata     (host_rdata)
   );

   for (genvar c = 0; c < N_CH; c++) begin : g_chan
      irq_agg_chan #(.EVT_W(EVT_W)) u_chan (
         .clk    (clk),
         .rst_n  (rst_n),
         .evt_in (evt_pulse[c*EVT_W +: EVT_W]),
         .en_wr  (en_wr[c]),
         .st_wr  (st_wr[c]),
         .wbits  (host_wdata[EVT_W-1:0]),
         .en_q   (en_flat[c*EVT_W +: EVT_W]),
         .st_q   (st_flat[c*EVT_W +: EVT_W]),
         .sum_q  (sum_vec[c])
      );
   end

   irq_agg_irqmap #(
      .N_CH(N_CH), .SHARED_IRQ(SHARED_IRQ), .IRQ_W(IRQ_W)
   ) u_irqmap (
      .sum_vec (sum_vec),
      .irq     (irq)
   );

endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk #(
   parameter int N_CH       = 4,
   parameter int EVT_W      = 15,
   parameter int DATA_W     = 32,
   parameter bit SHARED_IRQ = 1'b0,
   parameter int ADDR_W     = 4,
   parameter int IRQ_W      = 4
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic [N_CH*EVT_W-1:0]   evt_pulse,
   input logic                    host_wr,
   input logic [ADDR_W-1:0]       host_addr,
   input logic [DATA_W-1:0]       host_rdata,
   input logic [N_CH*EVT_W-1:0]   en_flat,
   input logic [N_CH-1:0]         sum_vec,
   input logic [IRQ_W-1:0]        irq
);

   // R1: summary is empty on the first cycle out of reset
   assert_reset_empty_R1: assert property (@(posedge clk)
      disable iff (!rst_n) $rose(rst_n) |-> (sum_vec == '0));

   // R2: enable read has zero upper bits
   assert_enable_upper_zero_R2: assert property (@(posedge clk)
      disable iff (!rst_n) (host_addr[1:0] == 2'd0) |-> (host_rdata[DATA_W-1:EVT_W] == '0));

   // R4: an enabled event sets its channel's summary bit
   for (genvar c = 0; c < N_CH; c++) begin : g_post
      assert_post_sets_summary_R4: assert property (@(posedge clk)
         disable iff (!rst_n)
         ((evt_pulse[c*EVT_W +: EVT_W] & en_flat[c*EVT_W +: EVT_W]) != '0) |=> sum_vec[c]);
   end

   // R6: no summary bit falls without a status clear write
   assert_summary_sticky_R6: assert property (@(posedge clk)
      disable iff (!rst_n)
      !(host_wr && host_addr[1:0] == 2'd1) |=> ((~sum_vec & $past(sum_vec)) == '0));

   // R8: a write to the summary with no events changes nothing
   assert_summary_readonly_R8: assert property (@(posedge clk)
      disable iff (!rst_n)
      (host_wr && host_addr[1:0] == 2'd2 && evt_pulse == '0) |=> $stable(sum_vec));

   // R9: interrupt lines follow the summary in the selected mode
   if (SHARED_IRQ) begin : g_chk_shared
      assert_irq_shared_R9: assert property (@(posedge clk)
         disable iff (!rst_n) irq[0] == (|sum_vec));
   end else begin : g_chk_per
      assert_irq_per_chan_R9: assert property (@(posedge clk)
         disable iff (!rst_n) irq == sum_vec);
   end

endmodule

bind irq_agg irq_agg_chk #(
   .N_CH(N_CH), .EVT_W(EVT_W), .DATA_W(DATA_W), .SHARED_IRQ(SHARED_IRQ),
   .ADDR_W(ADDR_W), .IRQ_W(SHARED_IRQ ? 1 : N_CH)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .evt_pulse  (evt_pulse),
   .host_wr    (host_wr),
   .host_addr  (host_addr),
   .host_rdata (host_rdata),
   .en_flat    (en_flat),
   .sum_vec    (sum_vec),
   .irq        (irq)
);

// File: tb/irq_agg_tb.sv
`timescale 1ns/1ps
module irq_agg_tb;

   localparam int N  = 4;
   localparam int EW = 15;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N*EW-1:0] evt = '0;
   logic          wr = 1'b0;
   logic [3:0]    addr = '0;
   logic [31:0]   wdata = '0;
   logic [31:0]   rdata, rdata_sh;
   logic [N-1:0]  sum_vec, sum_sh;
   logic [N-1:0]  irq;
   logic [0:0]    irq_sh;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   bit cmp_on = 1'b0;

   always #2.5 clk = ~clk;

   irq_agg #(.N_CH(N), .EVT_W(EW), .DATA_W(32), .SHARED_IRQ(1'b0)) u_dut (
      .clk(clk), .rst_n(rst_n), .evt_pulse(evt), .host_wr(wr), .host_addr(addr),
      .host_wdata(wdata), .host_rdata(rdata), .sum_vec(sum_vec), .irq(irq));

   irq_agg #(.N_CH(N), .EVT_W(EW), .DATA_W(32), .SHARED_IRQ(1'b1)) u_dut_sh (
      .clk(clk), .rst_n(rst_n), .evt_pulse(evt), .host_wr(wr), .host_addr(addr),
      .host_wdata(wdata), .host_rdata(rdata_sh), .sum_vec(sum_sh), .irq(irq_sh));

   // behavioural reference model
   logic [EW-1:0] m_st [N];
   logic [EW-1:0] m_en [N];
   logic [N-1:0]  m_sum;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int c = 0; c < N; c++) begin m_st[c] = '0; m_en[c] = '0; end
         m_sum = '0;
      end else begin
         for (int c = 0; c < N; c++) begin
            logic [EW-1:0] ev, nx;
            bit sw;
            ev = evt[c*EW +: EW];
            sw = wr && addr[1:0] == 2'd1 && addr[3:2] == c;
            nx = sw ? (m_st[c] & ~wdata[EW-1:0]) : m_st[c];
            if (ev != 0) begin
               nx = (nx | ev) & m_en[c];
               if (nx != 0) m_sum[c] = 1'b1;
               else if (sw) m_sum[c] = 1'b0;
            end else if (sw && nx == 0) m_sum[c] = 1'b0;
            m_st[c] = nx;
            if (wr && addr[1:0] == 2'd0 && addr[3:2] == c) m_en[c] = wdata[EW-1:0];
         end
      end
   end

   function automatic logic [31:0] m_rd(input logic [3:0] a);
      case (a[1:0])
         2'd0: return {17'b0, m_en[a[3:2]]};
         2'd1: return {17'b0, m_st[a[3:2]]};
         2'd2: return {28'b0, m_sum};
         default: return 32'h0;
      endcase
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // every-cycle comparison against the model
   always @(posedge clk) begin
      #1;
      if (rst_n && cmp_on && !done) begin
         check("R4 R6 sum_vec", {28'b0, sum_vec}, {28'b0, m_sum});
         check("R9 per-chan irq", {28'b0, irq}, {28'b0, m_sum});
         check("R9 shared irq", {31'b0, irq_sh}, {31'b0, |m_sum});
         check("R10 rdata", rdata, m_rd(addr));
         check("R10 rdata shared", rdata_sh, m_rd(addr));
      end
   end

   task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk); wr = 1'b1; addr = a; wdata = d; evt = '0;
      @(negedge clk); wr = 1'b0; wdata = '0;
   endtask

   task automatic post(input int c, input logic [EW-1:0] bits);
      @(negedge clk); wr = 1'b0; evt = '0; evt[c*EW +: EW] = bits;
      @(negedge clk); evt = '0;
   endtask

   task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk); wr = 1'b0; evt = '0; addr = a;
      #1 check(tag, rdata, exp);
   endtask

   task automatic sum_chk(input logic [N-1:0] exp, input string tag);
      @(negedge clk); #1;
      check(tag, {28'b0, sum_vec}, {28'b0, exp});
      check(tag, {28'b0, irq}, {28'b0, exp});
      check(tag, {31'b0, irq_sh}, {31'b0, |exp});
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      cmp_on = 1'b1;

      // R1 reset state
      rd_chk(4'h0, 32'h0, "R1 enable ch0");
      rd_chk(4'h5, 32'h0, "R1 status ch1");
      rd_chk(4'h2, 32'h0, "R1 summary");
      sum_chk(4'b0000, "R1 irq low");

      // R2 enable keeps 15 bits
      wr_reg(4'h0, 32'hFFFF_FFFF);
      rd_chk(4'h0, 32'h0000_7FFF, "R2 enable width");

      // R3/R4 masking at posting time
      wr_reg(4'h4, 32'h0000_0005);
      post(1, 15'h0007);
      rd_chk(4'h5, 32'h0000_0005, "R3 masked post");
      sum_chk(4'b0010, "R4 summary set");

      // R5 partial clear, upper bits ignored; R6 summary held
      wr_reg(4'h5, 32'hFFFF_0001);
      rd_chk(4'h5, 32'h0000_0004, "R5 w1c partial");
      sum_chk(4'b0010, "R6 held while nonzero");
      wr_reg(4'h5, 32'h0000_0004);
      rd_chk(4'h5, 32'h0000_0000, "R5 w1c last bit");
      sum_chk(4'b0000, "R6 dropped when empty");

      // R7 set beats clear on same bit
      post(0, 15'h0008);
      @(negedge clk); wr = 1'b1; addr = 4'h1; wdata = 32'h8;
      evt = '0; evt[0 +: EW] = 15'h0008;
      @(negedge clk); wr = 1'b0; evt = '0; wdata = '0;
      rd_chk(4'h1, 32'h0000_0008, "R7 set wins");
      sum_chk(4'b0001, "R7 summary kept");

      // R8 summary is read-only
      wr_reg(4'h2, 32'h0000_0000);
      rd_chk(4'h2, 32'h0000_0001, "R8 write zero ignored");
      wr_reg(4'h2, 32'hFFFF_FFFF);
      rd_chk(4'h2, 32'h0000_0001, "R8 write ones ignored");

      // R6 zero-result posting keeps the summary bit
      wr_reg(4'h8, 32'h1);
      post(2, 15'h0001);
      sum_chk(4'b0101, "R4 ch2 set");
      wr_reg(4'h8, 32'h0);
      post(2, 15'h0002);
      rd_chk(4'h9, 32'h0, "R3 disabled post empties status");
      sum_chk(4'b0101, "R6 sticky after zero post");
      wr_reg(4'h9, 32'h0);
      sum_chk(4'b0001, "R6 clear write drops");

      // R10 reserved select
      rd_chk(4'h3, 32'h0, "R10 reserved reads zero");
      rd_chk(4'hF, 32'h0, "R10 reserved ch3");

      // random traffic compared every cycle
      for (int i = 0; i < 600; i++) begin
         @(negedge clk);
         wr    = ($urandom % 3) == 0;
         addr  = 4'($urandom);
         wdata = $urandom;
         evt   = '0;
         for (int c = 0; c < N; c++)
            if (($urandom % 4) == 0) evt[c*EW +: EW] = EW'($urandom);
      end
      @(negedge clk); wr = 1'b0; evt = '0;
      repeat (3) @(negedge clk);
      finish_run();
   end

endmodule